// File: doc/BRIEF.md
# Frame-Buffer Word to Panel Pixel Formatter

This block sits between a frame-buffer fetch engine and a display panel's pixel bus. It accepts 32-bit memory words on a valid/ready stream and emits panel bus beats on a second valid/ready stream. A word holds either two packed RGB565 pixels or one RGB888 pixel in its low three bytes. A per-configuration byte-enable mask marks which bytes of every word carry pixel data.

A configuration write sets three things together: the pixel format code, the panel bus width code and the byte mask. Each pixel is then resized for the selected panel bus. On an 8-bit bus a 16-bit pixel leaves as two beats. A configuration write that the block cannot honour raises a sticky error flag, and the block stops moving data until a valid configuration is written. A clear input throws away the held word and any half-sent pixel.

Top module: `fb_pixel_formatter`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and cfg_err is 0. The active configuration is then pixel format code 0, bus code 0 and byte mask 4'hF.
- R2: A cycle with cfg_wr high loads the format code, bus code and mask. Format code 0 selects two RGB565 pixels per word and code 3 selects one RGB888 pixel per word. Bus codes are 0 for 16 bits, 1 for 8 bits, 2 for 18 bits and 3 for 24 bits.
- R3: cfg_err is set by a write of format code 1 or 2, or by format code 3 together with bus code 1. It is cleared only by a later write of a valid configuration. While it is set, in_ready and out_valid are both 0.
- R4: In format 0, the pixel in bits 15:0 is sent before the pixel in bits 31:16. A halfword is sent only if both of its mask bits are set (mask bits 1:0 for the low halfword, bits 3:2 for the high one). A word with neither halfword enabled is consumed and produces no output.
- R5: In format 3, one pixel is taken from bits 23:0. Byte i (bits 8i+7:8i) is forced to zero when mask bit i is clear. Bits 31:24 never reach the output.
- R6: On the 16-bit bus, out_data[15:0] carries an RGB565 pixel unchanged (red 15:11, green 10:5, blue 4:0). An RGB888 pixel (red 23:16, green 15:8, blue 7:0) is truncated to {r[7:3], g[7:2], b[7:3]}. out_data[23:16] is 0.
- R7: On the 18-bit bus, out_data[17:0] is {red6, green6, blue6} and bits 23:18 are 0. RGB888 keeps the top 6 bits of each colour. For RGB565, red and blue become 6 bits by repeating their most significant bit below the LSB, and green passes unchanged.
- R8: On the 24-bit bus, an RGB888 pixel passes unchanged. An RGB565 pixel is widened to {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]}.
- R9: On the 8-bit bus with format 0, each pixel is sent as two beats in out_data[7:0]: the low byte first, then the high byte. out_data[23:8] is 0.
- R10: While out_valid is high and out_ready is low, out_valid and out_data hold their values. A new word is accepted in the same cycle that the last beat of the held word is taken.
- R11: In a cycle with fifo_clear high, in_ready and out_valid are 0. From the next cycle on, the held word and any partly sent pixel are gone.
- R12: A configuration write also discards the held word and any partly sent pixel, in the same way as fifo_clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the configuration fields below |
| cfg_word_len | input | 2 | Pixel format code (0 = RGB565 pair, 3 = RGB888) |
| cfg_bus_width | input | 2 | Panel bus code (0 = 16, 1 = 8, 2 = 18, 3 = 24 bits) |
| cfg_byte_mask | input | WORD_W/8 | Byte-enable mask for input words |
| fifo_clear | input | 1 | Discard held word and partial pixel |
| in_valid | input | 1 | Input word valid |
| in_data | input | WORD_W | Frame-buffer word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_valid | output | 1 | Output beat valid |
| out_data | output | BUS_W | Panel bus beat, zero above the active width |
| out_ready | input | 1 | Panel side takes the beat |
| cfg_err | output | 1 | Sticky error for an unsupported configuration |

## Verification
The main sweep covers every supported pairing of pixel format and bus width. For each pairing it runs all sixteen byte masks, with several words whose halfwords and bytes differ from one another. Running every mask separates halfword selection from byte zeroing. Words with unequal halves and bytes expose a swapped pixel order, a swapped beat order, or a colour shifted into the wrong lane. Separate sequences cover the rejected codes, a stalled panel side with the next word arriving on the final beat, and a clear or reconfiguration while a word is held.

// File: rtl/fbpf_pkg.sv
package fbpf_pkg;

   localparam int PIX24_W = 24;
   localparam int HALF_W  = 16;

   typedef enum logic [1:0] {
      FMT_565  = 2'd0,
      FMT_RSV1 = 2'd1,
      FMT_RSV2 = 2'd2,
      FMT_888  = 2'd3
   } pix_fmt_e;

   typedef enum logic [1:0] {
      LANE_16 = 2'd0,
      LANE_8  = 2'd1,
      LANE_18 = 2'd2,
      LANE_24 = 2'd3
   } lane_e;

   typedef struct packed {
      pix_fmt_e fmt;
      lane_e    lane;
   } mode_t;

   // Configurations the datapath cannot honour.
   function automatic logic mode_illegal(mode_t m);
      return (m.fmt == FMT_RSV1) || (m.fmt == FMT_RSV2) ||
             ((m.fmt == FMT_888) && (m.lane == LANE_8));
   endfunction

endpackage

// File: rtl/fbpf_cfg_regs.sv
module fbpf_cfg_regs
   import fbpf_pkg::*;
#(
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  mode_t         mode_in,
   input  logic [NB-1:0] mask_in,
   output mode_t         mode_q,
   output logic [NB-1:0] mask_q,
   output logic          bad_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '{fmt: FMT_565, lane: LANE_16};
         mask_q <= '1;
         bad_q  <= 1'b0;
      end else if (wr) begin
         mode_q <= mode_in;
         mask_q <= mask_in;
         bad_q  <= mode_illegal(mode_in);
      end
   end

endmodule

// File: rtl/fbpf_word_hold.sv
module fbpf_word_hold #(
   parameter int WORD_W = 32,
   parameter int HALF_W = 16,
   parameter int PIX_W  = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  pair_mode,
   input  logic                  two_beat,
   input  logic [WORD_W/8-1:0]   mask,
   input  logic                  in_fire,
   input  logic [WORD_W-1:0]     in_word,
   input  logic                  out_fire,
   output logic                  held,
   output logic [PIX_W-1:0]      pix_raw,
   output logic                  beat_hi,
   output logic                  final_beat
);

   localparam int NB     = WORD_W / 8;
   localparam int SLOTS  = WORD_W / HALF_W;
   localparam int SEL_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam int HB     = HALF_W / 8;

   logic [WORD_W-1:0] word_q;
   logic [SLOTS-1:0]  pend_q;
   logic              beat_q;
   logic              vld_q;

   logic [WORD_W-1:0] masked;
   logic [SLOTS-1:0]  slot_ok;
   logic [SLOTS-1:0]  new_pend;
   logic [SLOTS-1:0]  rest_pend;
   logic [SEL_W-1:0]  sel;
   logic              last_slot;
   logic [HALF_W-1:0] half_pix;

   // Byte lanes with a clear mask bit are zeroed on capture.
   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign masked[8*b +: 8] = mask[b] ? in_word[8*b +: 8] : 8'h00;
   end

   // A halfword pixel is emitted only when all of its bytes are enabled.
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign slot_ok[s] = &mask[HB*s +: HB];
   end

   assign new_pend = pair_mode ? slot_ok : SLOTS'(1);

   // Lowest pending slot goes first.
   always_comb begin
      logic found;
      found = 1'b0;
      sel   = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (!found && pend_q[s]) begin
            sel   = SEL_W'(s);
            found = 1'b1;
         end
      end
   end

   assign rest_pend  = pend_q & ~(SLOTS'(1) << sel);
   assign last_slot  = (rest_pend == '0);
   assign half_pix   = word_q[HALF_W*sel +: HALF_W];
   assign pix_raw    = pair_mode ? {{(PIX_W-HALF_W){1'b0}}, half_pix}
                                 : word_q[PIX_W-1:0];
   assign held       = vld_q;
   assign beat_hi    = beat_q;
   assign final_beat = (!two_beat || beat_q) && last_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         pend_q <= '0;
         beat_q <= 1'b0;
         vld_q  <= 1'b0;
      end else if (flush) begin
         pend_q <= '0;
         beat_q <= 1'b0;
         vld_q  <= 1'b0;
      end else if (in_fire) begin
         word_q <= masked;
         pend_q <= new_pend;
         beat_q <= 1'b0;
         vld_q  <= |new_pend;
      end else if (out_fire) begin
         if (two_beat && !beat_q) begin
            beat_q <= 1'b1;
         end else begin
            beat_q <= 1'b0;
            pend_q <= rest_pend;
            vld_q  <= !last_slot;
         end
      end
   end

endmodule

// File: rtl/fbpf_bus_map.sv
module fbpf_bus_map
   import fbpf_pkg::*;
#(
   parameter int BUS_W    = 24,
   parameter bit FILL_MSB = 1'b1
) (
   input  mode_t              mode,
   input  logic [PIX24_W-1:0] pix,
   input  logic               beat_hi,
   output logic [BUS_W-1:0]   bus_data
);

   logic [4:0] r5, b5;
   logic [5:0] g6;
   logic [7:0] r8, g8, b8;
   logic [5:0] r5w6, b5w6;
   logic [7:0] r5w8, g6w8, b5w8;

   assign r5 = pix[15:11];
   assign g6 = pix[10:5];
   assign b5 = pix[4:0];
   assign r8 = pix[23:16];
   assign g8 = pix[15:8];
   assign b8 = pix[7:0];

   // Low-bit fill used when a narrow colour is widened.
   if (FILL_MSB) begin : g_fill_rep
      assign r5w6 = {r5, r5[4]};
      assign b5w6 = {b5, b5[4]};
      assign r5w8 = {r5, r5[4:2]};
      assign g6w8 = {g6, g6[5:4]};
      assign b5w8 = {b5, b5[4:2]};
   end else begin : g_fill_zero
      assign r5w6 = {r5, 1'b0};
      assign b5w6 = {b5, 1'b0};
      assign r5w8 = {r5, 3'b000};
      assign g6w8 = {g6, 2'b00};
      assign b5w8 = {b5, 3'b000};
   end

   always_comb begin
      bus_data = '0;
      if (mode.fmt == FMT_565) begin
         case (mode.lane)
            LANE_16: bus_data[15:0] = pix[15:0];
            LANE_8:  bus_data[7:0]  = beat_hi ? pix[15:8] : pix[7:0];
            LANE_18: bus_data[17:0] = {r5w6, g6, b5w6};
            default: bus_data[23:0] = {r5w8, g6w8, b5w8};
         endcase
      end else begin
         case (mode.lane)
            LANE_16: bus_data[15:0] = {r8[7:3], g8[7:2], b8[7:3]};
            LANE_18: bus_data[17:0] = {r8[7:2], g8[7:2], b8[7:2]};
            LANE_24: bus_data[23:0] = pix;
            default: bus_data       = '0;
         endcase
      end
   end

endmodule

// File: rtl/fb_pixel_formatter.sv
module fb_pixel_formatter
   import fbpf_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int BUS_W    = 24,
   parameter bit FILL_MSB = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [1:0]          cfg_word_len,
   input  logic [1:0]          cfg_bus_width,
   input  logic [WORD_W/8-1:0] cfg_byte_mask,
   input  logic                fifo_clear,
   input  logic                in_valid,
   input  logic [WORD_W-1:0]   in_data,
   output logic                in_ready,
   output logic                out_valid,
   output logic [BUS_W-1:0]    out_data,
   input  logic                out_ready,
   output logic                cfg_err
);

   localparam int NB = WORD_W / 8;

   if (WORD_W != 32) begin : g_bad_word
      $error("fb_pixel_formatter: WORD_W must be 32");
   end
   if (BUS_W < PIX24_W) begin : g_bad_bus
      $error("fb_pixel_formatter: BUS_W must be at least 24");
   end

   mode_t             mode_in, mode_q;
   logic [NB-1:0]     mask_q;
   logic              bad_q;
   logic              flush;
   logic              pair_mode, two_beat;
   logic              held, beat_hi, final_beat;
   logic              in_fire, out_fire;
   logic [PIX24_W-1:0] pix_raw;

   assign mode_in = '{fmt: pix_fmt_e'(cfg_word_len), lane: lane_e'(cfg_bus_width)};

   fbpf_cfg_regs #(.NB(NB)) i_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cfg_wr),
      .mode_in (mode_in),
      .mask_in (cfg_byte_mask),
      .mode_q  (mode_q),
      .mask_q  (mask_q),
      .bad_q   (bad_q)
   );

   assign flush     = fifo_clear | cfg_wr;
   assign pair_mode = (mode_q.fmt == FMT_565);
   assign two_beat  = pair_mode && (mode_q.lane == LANE_8);

   assign out_valid = held && !bad_q && !flush;
   assign out_fire  = out_valid && out_ready;
   assign in_ready  = !bad_q && !flush && (!held || (out_fire && final_beat));
   assign in_fire   = in_valid && in_ready;
   assign cfg_err   = bad_q;

   fbpf_word_hold #(
      .WORD_W (WORD_W),
      .HALF_W (HALF_W),
      .PIX_W  (PIX24_W)
   ) i_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .pair_mode  (pair_mode),
      .two_beat   (two_beat),
      .mask       (mask_q),
      .in_fire    (in_fire),
      .in_word    (in_data),
      .out_fire   (out_fire),
      .held       (held),
      .pix_raw    (pix_raw),
      .beat_hi    (beat_hi),
      .final_beat (final_beat)
   );

   fbpf_bus_map #(
      .BUS_W    (BUS_W),
      .FILL_MSB (FILL_MSB)
   ) i_map (
      .mode     (mode_q),
      .pix      (pix_raw),
      .beat_hi  (beat_hi),
      .bus_data (out_data)
   );

endmodule

// File: rtl/fb_pixel_formatter_chk.sv
module fb_pixel_formatter_chk #(
   parameter int BUS_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic             fifo_clear,
   input logic             in_ready,
   input logic             out_valid,
   input logic [BUS_W-1:0] out_data,
   input logic             out_ready,
   input logic             cfg_err
);

   AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!out_valid && !in_ready)); // R3

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(cfg_err)); // R3

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !fifo_clear && !cfg_wr) |=>
      (fifo_clear || cfg_wr || (out_valid && $stable(out_data)))); // R10

   AST_FLUSH_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_clear || cfg_wr) |-> (!out_valid && !in_ready)); // R11

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_clear || cfg_wr) |=> !out_valid); // R12

endmodule

bind fb_pixel_formatter fb_pixel_formatter_chk #(.BUS_W(BUS_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .fifo_clear (fifo_clear),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_data   (out_data),
   .out_ready  (out_ready),
   .cfg_err    (cfg_err)
);

// File: tb/test_fb_pixel_formatter.sv
module test_fb_pixel_formatter;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_word_len = 2'd0;
   logic [1:0]  cfg_bus_width = 2'd0;
   logic [3:0]  cfg_byte_mask = 4'hF;
   logic        fifo_clear = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [23:0] out_data;
   logic        out_ready = 1'b1;
   logic        cfg_err;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fb_pixel_formatter i_fb_pixel_formatter (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_wr        (cfg_wr),
      .cfg_word_len  (cfg_word_len),
      .cfg_bus_width (cfg_bus_width),
      .cfg_byte_mask (cfg_byte_mask),
      .fifo_clear    (fifo_clear),
      .in_valid      (in_valid),
      .in_data       (in_data),
      .in_ready      (in_ready),
      .out_valid     (out_valid),
      .out_data      (out_data),
      .out_ready     (out_ready),
      .cfg_err       (cfg_err)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic configure(input logic [1:0] wl, input logic [1:0] bw, input logic [3:0] m);
      @(negedge clk);
      cfg_word_len = wl; cfg_bus_width = bw; cfg_byte_mask = m; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // Expected beats from the requirements.
   task automatic model(input logic [1:0] wl, input logic [1:0] bw, input logic [3:0] m,
                        input logic [31:0] w, output int n, output logic [3:0][23:0] e);
      logic [15:0] p;
      logic [23:0] q;
      n = 0;
      e = '0;
      if (wl == 2'd0) begin
         for (int s = 0; s < 2; s++) begin
            if (m[2*s] && m[2*s+1]) begin
               p = w[16*s +: 16];
               case (bw)
                  2'd0: begin e[n] = {8'h00, p}; n++; end
                  2'd1: begin e[n] = {16'h0, p[7:0]}; n++; e[n] = {16'h0, p[15:8]}; n++; end
                  2'd2: begin e[n] = {6'h0, p[15:11], p[15], p[10:5], p[4:0], p[4]}; n++; end
                  default: begin e[n] = {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]}; n++; end
               endcase
            end
         end
      end else begin
         for (int b = 0; b < 3; b++) q[8*b +: 8] = m[b] ? w[8*b +: 8] : 8'h00;
         case (bw)
            2'd0: e[0] = {8'h00, q[23:19], q[15:10], q[7:3]};
            2'd2: e[0] = {6'h0, q[23:18], q[15:10], q[7:2]};
            default: e[0] = q;
         endcase
         n = 1;
      end
   endtask

   task automatic send_collect(input logic [31:0] w, output int n, output logic [3:0][23:0] got);
      n = 0;
      got = '0;
      @(negedge clk);
      in_valid = 1'b1; in_data = w; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < 5; k++) begin
         #1;
         if (out_valid) begin
            if (n < 4) got[n] = out_data;
            n++;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n, en;
      logic [3:0][23:0] got, e;
      string tag;
      logic [31:0] w1, w2;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
      chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      chk(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);

      // R1: default configuration is an RGB565 pair on a 16-bit bus.
      send_collect(32'h1234_ABCD, n, got);
      chk(n == 2, "R1 beat count", n, 2);
      chk(got[0] == 24'h00ABCD, "R1 first pixel", got[0], 24'h00ABCD);
      chk(got[1] == 24'h001234, "R1 second pixel", got[1], 24'h001234);

      // Sweep all supported format/bus pairs, masks and several words.
      for (int wi = 0; wi < 2; wi++) begin
         for (int bi = 0; bi < 4; bi++) begin
            if (wi == 1 && bi == 1) continue;
            for (int mi = 0; mi < 16; mi++) begin
               configure(wi ? 2'd3 : 2'd0, 2'(bi), 4'(mi));
               for (int k = 0; k < 3; k++) begin
                  w1 = 32'h9E37_79B9 * (k + 1) + 32'h0101_0101 * mi;
                  model(wi ? 2'd3 : 2'd0, 2'(bi), 4'(mi), w1, en, e);
                  send_collect(w1, n, got);
                  case (bi)
                     0: tag = wi ? "R5/R6" : "R4/R6";
                     1: tag = "R4/R9";
                     2: tag = wi ? "R5/R7" : "R4/R7";
                     default: tag = wi ? "R5/R8" : "R4/R8";
                  endcase
                  chk(n == en, {tag, " count"}, n, en);
                  for (int j = 0; j < 4; j++)
                     if (j < en) chk(got[j] == e[j], {tag, " beat"}, got[j], e[j]);
               end
            end
         end
      end

      // R3: illegal combinations set a sticky error that blocks traffic.
      configure(2'd3, 2'd1, 4'h7);
      #1;
      chk(cfg_err == 1'b1, "R3 888 on 8-bit", cfg_err, 1);
      chk(in_ready == 1'b0, "R3 in_ready", in_ready, 0);
      @(negedge clk);
      in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         chk(out_valid == 1'b0 && cfg_err == 1'b1, "R3 blocked", out_valid, 0);
      end
      in_valid = 1'b0;
      configure(2'd1, 2'd0, 4'hF);
      #1;
      chk(cfg_err == 1'b1, "R3 format code 1", cfg_err, 1);
      configure(2'd2, 2'd3, 4'hF);
      #1;
      chk(cfg_err == 1'b1, "R2 format code 2", cfg_err, 1);
      configure(2'd0, 2'd0, 4'hF);
      #1;
      chk(cfg_err == 1'b0, "R2 valid write clears", cfg_err, 0);

      // R10: stall, then accept a new word on the final beat.
      w1 = 32'h5555_AAAA; w2 = 32'h3C3C_C3C3;
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_data = w1;
      @(negedge clk);
      in_valid = 1'b0; #1;
      chk(out_valid && out_data == 24'h00AAAA, "R10 first held", out_data, 24'h00AAAA);
      chk(in_ready == 1'b0, "R10 no accept while held", in_ready, 0);
      @(negedge clk); #1;
      chk(out_valid && out_data == 24'h00AAAA, "R10 stable", out_data, 24'h00AAAA);
      @(negedge clk);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b1; in_data = w2; #1;
      chk(out_valid && out_data == 24'h005555, "R10 second pixel", out_data, 24'h005555);
      chk(in_ready == 1'b1, "R10 accept on final beat", in_ready, 1);
      @(negedge clk);
      in_valid = 1'b0; #1;
      chk(out_valid && out_data == 24'h00C3C3, "R10 next word", out_data, 24'h00C3C3);
      @(negedge clk); @(negedge clk); #1;
      chk(out_valid == 1'b0, "R10 drained", out_valid, 0);

      // R11: clear discards a held word.
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_data = w1;
      @(negedge clk);
      in_valid = 1'b0; fifo_clear = 1'b1; #1;
      chk(out_valid == 1'b0 && in_ready == 1'b0, "R11 during clear", {out_valid, in_ready}, 0);
      @(negedge clk);
      fifo_clear = 1'b0; #1;
      chk(out_valid == 1'b0, "R11 discarded", out_valid, 0);
      chk(in_ready == 1'b1, "R11 ready again", in_ready, 1);

      // R12: reconfiguration discards a half-sent pixel.
      configure(2'd0, 2'd1, 4'hF);
      @(negedge clk);
      out_ready = 1'b1; in_valid = 1'b1; in_data = 32'h0000_F00D;
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1; #1;
      chk(out_valid && out_data == 24'h00000D, "R9 low byte first", out_data, 24'h00000D);
      @(negedge clk);
      cfg_wr = 1'b1; #1;
      chk(out_valid == 1'b0, "R12 during write", out_valid, 0);
      @(negedge clk);
      cfg_wr = 1'b0; #1;
      chk(out_valid == 1'b0, "R12 discarded", out_valid, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule